// File: doc/BRIEF.md
# Upset-tolerant duplicated register file

This block is the integer register file of a pipelined processor. It has two read ports and one write port, and it is built so that a single flipped storage bit never reaches the pipeline as silent bad data. Every word is kept in two separate arrays, the primary and the secondary. Both arrays take the same value on every write. Each stored entry also carries one parity bit for each byte of the word.

Each read port always reads the primary copy. The parity check runs in the same cycle as the array lookup, so the registered read data and a registered error flag become valid together, one cycle after the address is presented. A read never takes longer than this. When the primary copy is bad and the secondary copy is good, the port returns the secondary word and raises its error flag, and the pipeline restarts the instruction. The block stores the good entry and writes it back into the primary array in the next cycle that has no architectural write, so the reissued read finds clean data. When both copies are bad, an uncorrectable output pulses and nothing is written back. A test input flips any single bit of either copy, so that upsets can be injected on purpose.

Top module: `dual_copy_regfile`

## Requirements
- R1: The file holds 136 words of 32 bits. A write with `wr_en` high stores `wr_data` at `wr_addr` in both copies at the clock edge. Each read port returns the word at its address on its data output one cycle after the address is presented.
- R2: A stored entry is 36 bits wide. Bits [31:0] hold the data, and bit 32+i holds the even parity (XOR) of data bits [8i+7:8i], for i = 0 to 3. A flip in any data bit or any parity bit of the primary copy is detected.
- R3: In the same cycle as the read data, a port's error flag goes high exactly when the primary entry read at that port's address fails its parity check.
- R4: When the primary entry fails and the secondary entry passes, the port returns the secondary data. When only the secondary entry is damaged, the port returns the primary data with no error.
- R5: After a single-copy error, the secondary entry is written into the primary array at the first clock edge where `wr_en` is low. Port A's pending repair goes before port B's. A repair stays pending through any number of write cycles.
- R6: An architectural write to an address whose repair is still pending cancels that repair. The newly written value is kept.
- R7: When both copies fail at a read address, `uncorr` is high for that read cycle together with the port's error flag, and that address is never repaired.
- R8: A read of the address being written in the same cycle returns the new write data, with no parity check and the error flag low.
- R9: With `inj_en` high, bit `inj_bit` (0 to 35, using the layout in R2) of copy `inj_copy` (0 = primary, 1 = secondary) at `inj_addr` is inverted at the clock edge. This does not happen when a write or repair lands on that copy and address in the same cycle.
- R10: After reset, every entry of both copies is zero with valid parity, and the read data, error flags and `uncorr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr_a | input | 8 | Read address, port A |
| rd_addr_b | input | 8 | Read address, port B |
| rd_data_a | output | 32 | Registered read data, port A |
| rd_data_b | output | 32 | Registered read data, port B |
| err_a | output | 1 | Primary parity error on port A (restart request) |
| err_b | output | 1 | Primary parity error on port B (restart request) |
| uncorr | output | 1 | Both copies failed on a read in the previous cycle |
| inj_en | input | 1 | Test: flip one stored bit |
| inj_copy | input | 1 | Test: copy to damage, 0 = primary |
| inj_addr | input | 8 | Test: address to damage |
| inj_bit | input | 6 | Test: entry bit to flip |

## Verification
Two functions can fall in the same cycle: a pending scrub write-back and an architectural write, or two repairs that both become pending at once. The bench provokes the first case by keeping `wr_en` high for several cycles after a detection, then writing the damaged address itself. It judges the result by reading the address again, which must still flag an error while the writes continue and must return the newly written word once the repair has been cancelled. For the second case, both ports detect damage in the same cycle. After a single idle cycle, port A's address must read clean while port B's still flags, which confirms the order in which the repairs are made.

// File: rtl/dual_copy_regfile.sv
module dual_copy_regfile #(
  parameter int DEPTH = 136,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = WIDTH / 8,
  localparam int EW = WIDTH + PW,
  localparam int BW = $clog2(EW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [WIDTH-1:0] rd_data_a,
  output logic [WIDTH-1:0] rd_data_b,
  output logic             err_a,
  output logic             err_b,
  output logic             uncorr,
  input  logic             inj_en,
  input  logic             inj_copy,
  input  logic [AW-1:0]    inj_addr,
  input  logic [BW-1:0]    inj_bit
);

  function automatic logic [PW-1:0] byte_par(input logic [WIDTH-1:0] d);
    for (int i = 0; i < PW; i++) byte_par[i] = ^d[8*i +: 8];
  endfunction

  function automatic logic ent_ok(input logic [EW-1:0] e);
    return byte_par(e[WIDTH-1:0]) == e[EW-1:WIDTH];
  endfunction

  logic [EW-1:0]    prim [DEPTH];
  logic [EW-1:0]    sec  [DEPTH];
  logic [AW-1:0]    ra   [2];
  logic [WIDTH-1:0] rdq  [2];
  logic             errq [2];
  logic             dbl  [2];
  logic             det  [2];
  logic             rep_v    [2];
  logic [AW-1:0]    rep_addr [2];
  logic [EW-1:0]    rep_ent  [2];
  logic             fire [2];

  wire [EW-1:0] wr_ent = {byte_par(wr_data), wr_data};

  assign ra[0] = rd_addr_a;
  assign ra[1] = rd_addr_b;
  assign fire[0] = rep_v[0] && !wr_en;
  assign fire[1] = rep_v[1] && !wr_en && !rep_v[0];

  wire [AW-1:0] fix_addr = fire[0] ? rep_addr[0] : rep_addr[1];
  wire fix_any = fire[0] || fire[1];
  wire inj_blk = (wr_en && wr_addr == inj_addr) ||
                 (!inj_copy && fix_any && fix_addr == inj_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        prim[i] <= '0;
        sec[i]  <= '0;
      end
    end else begin
      if (wr_en) begin
        prim[wr_addr] <= wr_ent;
        sec[wr_addr]  <= wr_ent;
      end else if (fix_any) begin
        prim[fix_addr] <= fire[0] ? rep_ent[0] : rep_ent[1];
      end
      if (inj_en && !inj_blk) begin
        if (inj_copy) sec[inj_addr][inj_bit]  <= ~sec[inj_addr][inj_bit];
        else          prim[inj_addr][inj_bit] <= ~prim[inj_addr][inj_bit];
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_port
    wire [EW-1:0] p0 = prim[ra[g]];
    wire [EW-1:0] p1 = sec[ra[g]];
    wire byp  = wr_en && wr_addr == ra[g];
    wire bad0 = !byp && !ent_ok(p0);
    wire bad1 = !ent_ok(p1);
    assign dbl[g] = bad0 && bad1;
    assign det[g] = bad0 && !bad1;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rdq[g]      <= '0;
        errq[g]     <= 1'b0;
        rep_v[g]    <= 1'b0;
        rep_addr[g] <= '0;
        rep_ent[g]  <= '0;
      end else begin
        rdq[g]  <= byp ? wr_data : (bad0 ? p1[WIDTH-1:0] : p0[WIDTH-1:0]);
        errq[g] <= bad0;
        if (fire[g] || (rep_v[g] && wr_en && wr_addr == rep_addr[g])) begin
          rep_v[g] <= 1'b0;
        end else if (det[g] && !rep_v[g]) begin
          rep_v[g]    <= 1'b1;
          rep_addr[g] <= ra[g];
          rep_ent[g]  <= p1;
        end
      end
    end

    AST_REPAIR_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_v[g] && wr_en && wr_addr != rep_addr[g]) |=> rep_v[g]); // R5
    AST_REPAIR_HEALS: assert property (@(posedge clk) disable iff (!rst_n)
      fire[g] |=> ent_ok(prim[$past(rep_addr[g])])); // R5
  end

  always_ff @(posedge clk) begin
    if (!rst_n) uncorr <= 1'b0;
    else        uncorr <= dbl[0] || dbl[1];
  end

  assign rd_data_a = rdq[0];
  assign rd_data_b = rdq[1];
  assign err_a = errq[0];
  assign err_b = errq[1];

  AST_COPIES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inj_en) |=> prim[$past(wr_addr)] == sec[$past(wr_addr)]); // R1
  AST_WRITE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_ok(sec[$past(wr_addr)])); // R2
  AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == rd_addr_a) |=> (!err_a && rd_data_a == $past(wr_data))); // R8
  AST_UNC_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr |-> (err_a || err_b)); // R7

endmodule

// File: tb/tb_dual_copy_regfile.sv
module tb_dual_copy_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0] rd_addr_a = '0;
  logic [7:0] rd_addr_b = '0;
  logic [31:0] rd_data_a, rd_data_b;
  logic err_a, err_b, uncorr;
  logic inj_en = 1'b0;
  logic inj_copy = 1'b0;
  logic [7:0] inj_addr = '0;
  logic [5:0] inj_bit = '0;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dual_copy_regfile dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .rd_data_a(rd_data_a),
    .rd_data_b(rd_data_b), .err_a(err_a), .err_b(err_b), .uncorr(uncorr),
    .inj_en(inj_en), .inj_copy(inj_copy), .inj_addr(inj_addr), .inj_bit(inj_bit));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic inj(input logic c, input logic [7:0] a, input logic [5:0] b);
    inj_en = 1'b1; inj_copy = c; inj_addr = a; inj_bit = b;
    tick();
    inj_en = 1'b0;
  endtask

  task automatic idle;
    wr_en = 1'b0; rd_addr_a = 8'd0; rd_addr_b = 8'd0;
    tick();
  endtask

  task automatic t_reset;
    chk_eq("R10 data_a", rd_data_a, 32'h0);
    chk_eq("R10 flags", {29'd0, err_a, err_b, uncorr}, 32'h0);
    rd_addr_a = 8'd135; rd_addr_b = 8'd64;
    tick();
    chk_eq("R10 read 135", rd_data_a, 32'h0);
    chk_eq("R10 read 64", rd_data_b, 32'h0);
    chk_eq("R10 no err", {30'd0, err_a, err_b}, 32'h0);
  endtask

  task automatic t_basic;
    wr(8'd3, 32'hA5A5_1234);
    wr(8'd135, 32'h0F0F_F0F0);
    rd_addr_a = 8'd3; rd_addr_b = 8'd135;
    tick();
    chk_eq("R1 port A", rd_data_a, 32'hA5A5_1234);
    chk_eq("R1 port B", rd_data_b, 32'h0F0F_F0F0);
  endtask

  task automatic t_single;
    wr(8'd5, 32'hCAFE_0005);
    inj(1'b0, 8'd5, 6'd3);
    wr_en = 1'b1; wr_addr = 8'd100; wr_data = 32'h1; rd_addr_a = 8'd5;
    tick();
    chk_eq("R3 err_a set", {31'd0, err_a}, 32'd1);
    chk_eq("R4 secondary data", rd_data_a, 32'hCAFE_0005);
    tick();
    chk_eq("R5 still pending while writing", {31'd0, err_a}, 32'd1);
    idle();
    rd_addr_a = 8'd5;
    tick();
    chk_eq("R5 repaired err", {31'd0, err_a}, 32'd0);
    chk_eq("R5 repaired data", rd_data_a, 32'hCAFE_0005);
  endtask

  task automatic t_parity_bit;
    wr(8'd16, 32'h1357_9BDF);
    inj(1'b0, 8'd16, 6'd33);
    rd_addr_b = 8'd16;
    tick();
    chk_eq("R2 parity bit flip seen", {31'd0, err_b}, 32'd1);
    idle();
    rd_addr_b = 8'd16;
    tick();
    chk_eq("R2 parity bit repaired", {31'd0, err_b}, 32'd0);
    wr(8'd20, 32'h2020_2020);
    inj(1'b1, 8'd20, 6'd7);
    rd_addr_a = 8'd20;
    tick();
    chk_eq("R4 secondary-only damage no err", {31'd0, err_a}, 32'd0);
    chk_eq("R4 primary data", rd_data_a, 32'h2020_2020);
  endtask

  task automatic t_double;
    wr(8'd7, 32'h7777_0007);
    inj(1'b0, 8'd7, 6'd0);
    inj(1'b1, 8'd7, 6'd5);
    rd_addr_a = 8'd7;
    tick();
    chk_eq("R7 err and uncorr", {30'd0, err_a, uncorr}, 32'd3);
    idle();
    chk_eq("R7 uncorr drops", {31'd0, uncorr}, 32'd0);
    idle();
    rd_addr_a = 8'd7;
    tick();
    chk_eq("R7 not repaired", {30'd0, err_a, uncorr}, 32'd3);
  endtask

  task automatic t_bypass;
    wr(8'd9, 32'h0000_0009);
    inj(1'b0, 8'd9, 6'd12);
    wr_en = 1'b1; wr_addr = 8'd9; wr_data = 32'h9999_BEEF;
    rd_addr_a = 8'd9; rd_addr_b = 8'd9;
    tick();
    chk_eq("R8 bypass A", rd_data_a, 32'h9999_BEEF);
    chk_eq("R8 bypass B", rd_data_b, 32'h9999_BEEF);
    chk_eq("R8 no err", {30'd0, err_a, err_b}, 32'd0);
    wr_en = 1'b0;
    tick();
    chk_eq("R8 stored value", rd_data_a, 32'h9999_BEEF);
  endtask

  task automatic t_dual;
    wr(8'd11, 32'h1111_AAAA);
    wr(8'd12, 32'h1212_BBBB);
    inj(1'b0, 8'd11, 6'd20);
    inj(1'b0, 8'd12, 6'd31);
    wr_en = 1'b1; wr_addr = 8'd100; wr_data = 32'h2;
    rd_addr_a = 8'd11; rd_addr_b = 8'd12;
    tick();
    chk_eq("R3 both ports err", {30'd0, err_a, err_b}, 32'd3);
    chk_eq("R4 port B secondary", rd_data_b, 32'h1212_BBBB);
    idle();
    rd_addr_a = 8'd11; rd_addr_b = 8'd12;
    tick();
    chk_eq("R5 port A repaired first", {30'd0, err_a, err_b}, 32'd1);
    tick();
    chk_eq("R5 port B repaired next", {30'd0, err_a, err_b}, 32'd0);
  endtask

  task automatic t_cancel;
    wr(8'd14, 32'h0E0E_0E0E);
    inj(1'b0, 8'd14, 6'd9);
    wr_en = 1'b1; wr_addr = 8'd100; wr_data = 32'h3; rd_addr_a = 8'd14;
    tick();
    chk_eq("R6 detect", {31'd0, err_a}, 32'd1);
    rd_addr_a = 8'd0;
    wr(8'd14, 32'hD00D_F00D);
    idle();
    rd_addr_a = 8'd14;
    tick();
    chk_eq("R6 new value kept", rd_data_a, 32'hD00D_F00D);
    chk_eq("R6 no err", {31'd0, err_a}, 32'd0);
  endtask

  task automatic t_inject_blocked;
    wr_en = 1'b1; wr_addr = 8'd30; wr_data = 32'h3030_3030;
    inj_en = 1'b1; inj_copy = 1'b0; inj_addr = 8'd30; inj_bit = 6'd1;
    tick();
    wr_en = 1'b0; inj_en = 1'b0;
    rd_addr_a = 8'd30;
    tick();
    chk_eq("R9 write wins over inject", {31'd0, err_a}, 32'd0);
    chk_eq("R9 data intact", rd_data_a, 32'h3030_3030);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_single();
    t_parity_bit();
    t_double();
    t_bypass();
    t_dual();
    t_cancel();
    t_inject_blocked();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule